// File: doc/BRIEF.md
# Split-Width Register Access Bridge

The bridge lets a host with a 16-bit data bus reach a bank of 24-bit device registers. Every 24-bit register is handled as two 16-bit host transfers. A single 16-bit staging register at host offset 0 carries the top byte of a register in its upper half. The same staging register also holds an active-low reset bit for the device. The block decodes two address windows, each indexed by register number: one for reads and one for writes. Toward the device it drives an internal 24-bit port with address, read-enable, write-enable, write-data and read-data signals. The device returns read data combinationally in the cycle when read-enable is high.

To write a register, the host first writes the top byte into bits 15:8 of the staging register. It then writes the low 16 bits into the write window, and that second transfer commits the full 24-bit word in one device write. To read a register, the host reads the read window. It gets the low 16 bits, and the top byte is copied into the staging register, where a read of offset 0 returns it. Any other access is completed with no effect, and a read of it returns zero.

Each host transfer is a one-cycle request pulse and is answered by a one-cycle acknowledge. A state machine steps through four states: ST_IDLE, ST_FETCH, ST_COMMIT and ST_RESP. A request in ST_IDLE moves it to ST_FETCH for a window read, to ST_COMMIT for a window write, and straight to ST_RESP for anything else. ST_FETCH and ST_COMMIT always move on to ST_RESP, which raises the acknowledge and returns to ST_IDLE.

Top module: `split_reg_bridge`

## Requirements
- R1: After reset, host_ack, dev_we and dev_re are low, dev_rst_n is low, and a read of offset 0 returns 0x0000.
- R2: A write to host address 0 stores all 16 bits of host_wdata in the staging register, and a later read of address 0 returns them.
- R3: dev_rst_n follows staging bit 6 (mask 0x40): 0 holds the device in reset and 1 releases it. The new value appears on the cycle after a write to address 0 is accepted.
- R4: A read at address 0x80000 + (n << 4), for n from 0 to 1023, returns bits 15:0 of device register n.
- R5: That window read also loads bits 23:16 of register n into staging bits 15:8 and leaves staging bits 7:0 unchanged.
- R6: A write at address 0xA0000 + (n << 4) writes {staging[15:8], host_wdata} to device register n.
- R7: Each window write produces exactly one dev_we pulse, one cycle long. No other access raises dev_we.
- R8: An access at any other address has no effect. This covers a nonzero low nibble inside a window, a write to the read window, a read of the write window, and any address outside the windows and 0. Such an access raises neither dev_we nor dev_re, leaves the staging register unchanged, and returns 0x0000 on a read.
- R9: Every request gets one acknowledge, one cycle long, with host_rdata valid. It arrives 1 cycle after the request for staging and ignored accesses, and 2 cycles after for window accesses.
- R10: A window read raises dev_re for exactly one cycle, with dev_addr equal to the register number n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | One-cycle request pulse |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 20 | Host byte address |
| host_wdata | input | 16 | Host write data |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 16 | Read data, valid with host_ack |
| dev_addr | output | 10 | Device register number |
| dev_we | output | 1 | Device write strobe |
| dev_wdata | output | 24 | Device write data |
| dev_re | output | 1 | Device read enable |
| dev_rdata | input | 24 | Device read data, valid while dev_re is high |
| dev_rst_n | output | 1 | Active-low device reset |

## Verification
The assertions assume that the host issues a new request only after the previous one has been acknowledged. They also assume that host_req is a single-cycle pulse, and that the device returns dev_rdata in the same cycle as dev_re. The bench drives every transfer through one task that pulses the request and waits for the acknowledge before the next transfer starts, so back-to-back or overlapping requests never occur. The random mix draws register numbers across the whole index range and spreads the ignored addresses over every kind of miss that R8 names.

// File: rtl/split_bridge_pkg.sv
package split_bridge_pkg;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_STG_RD,
        ACC_STG_WR,
        ACC_WIN_RD,
        ACC_WIN_WR
    } acc_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_COMMIT,
        ST_RESP
    } bridge_state_e;

endpackage

// File: rtl/sbr_decode.sv
module sbr_decode
    import split_bridge_pkg::*;
#(
    parameter int HADDR_W = 20,
    parameter int IDX_W = 10,
    parameter int IDX_SHIFT = 4,
    parameter logic [HADDR_W-1:0] RD_BASE = 20'h80000,
    parameter logic [HADDR_W-1:0] WR_BASE = 20'hA0000
) (
    input  logic [HADDR_W-1:0] addr,
    input  logic               we,
    output acc_kind_e          kind,
    output logic [IDX_W-1:0]   idx
);
    localparam int TAG_LSB = IDX_SHIFT + IDX_W;
    localparam logic [HADDR_W-TAG_LSB-1:0] RD_TAG = RD_BASE[HADDR_W-1:TAG_LSB];
    localparam logic [HADDR_W-TAG_LSB-1:0] WR_TAG = WR_BASE[HADDR_W-1:TAG_LSB];

    logic aligned;

    generate
        if (IDX_SHIFT > 0) begin : g_align_check
            assign aligned = (addr[IDX_SHIFT-1:0] == '0);
        end else begin : g_no_align
            assign aligned = 1'b1;
        end
    endgenerate

    assign idx = addr[IDX_SHIFT +: IDX_W];

    always_comb begin
        kind = ACC_NONE;
        if (addr == '0) begin
            kind = we ? ACC_STG_WR : ACC_STG_RD;
        end else if (aligned && !we && addr[HADDR_W-1:TAG_LSB] == RD_TAG) begin
            kind = ACC_WIN_RD;
        end else if (aligned && we && addr[HADDR_W-1:TAG_LSB] == WR_TAG) begin
            kind = ACC_WIN_WR;
        end
    end

endmodule

// File: rtl/sbr_stage.sv
module sbr_stage #(
    parameter int HDATA_W = 16,
    parameter int HI_W = 8,
    parameter int RST_BIT = 6,
    parameter logic [HDATA_W-1:0] RESET_VAL = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [HDATA_W-1:0] wr_data,
    input  logic               hi_ld,
    input  logic [HI_W-1:0]    hi_data,
    output logic [HDATA_W-1:0] q,
    output logic               dev_rst_n
);
    logic [HDATA_W-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= RESET_VAL;
        end else if (wr_en) begin
            stage_q <= wr_data;
        end else if (hi_ld) begin
            stage_q[HDATA_W-1 -: HI_W] <= hi_data;
        end
    end

    assign q = stage_q;
    assign dev_rst_n = stage_q[RST_BIT];

endmodule

// File: rtl/sbr_fsm.sv
module sbr_fsm
    import split_bridge_pkg::*;
#(
    parameter int HDATA_W = 16,
    parameter int REG_W = 24,
    parameter int IDX_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  acc_kind_e          kind,
    input  logic [IDX_W-1:0]   idx,
    input  logic [HDATA_W-1:0] host_wdata,
    input  logic [HDATA_W-1:0] stage_q,
    input  logic [REG_W-1:0]   dev_rdata,
    output logic               host_ack,
    output logic [HDATA_W-1:0] host_rdata,
    output logic [IDX_W-1:0]   dev_addr,
    output logic               dev_re,
    output logic               dev_we,
    output logic [REG_W-1:0]   dev_wdata,
    output logic               stage_wr,
    output logic               stage_hi_ld,
    output logic [REG_W-HDATA_W-1:0] stage_hi_data
);
    localparam int HI_W = REG_W - HDATA_W;

    bridge_state_e state, state_nx;

    logic [IDX_W-1:0]   addr_q;
    logic [REG_W-1:0]   wdata_q;
    logic [HDATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (req) begin
                    case (kind)
                        ACC_WIN_RD: state_nx = ST_FETCH;
                        ACC_WIN_WR: state_nx = ST_COMMIT;
                        default:    state_nx = ST_RESP;
                    endcase
                end
            end
            ST_FETCH:  state_nx = ST_RESP;
            ST_COMMIT: state_nx = ST_RESP;
            ST_RESP:   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        host_ack    = 1'b0;
        dev_re      = 1'b0;
        dev_we      = 1'b0;
        stage_wr    = 1'b0;
        stage_hi_ld = 1'b0;
        unique case (state)
            ST_IDLE:   stage_wr    = req && (kind == ACC_STG_WR);
            ST_FETCH: begin
                dev_re      = 1'b1;
                stage_hi_ld = 1'b1;
            end
            ST_COMMIT: dev_we      = 1'b1;
            ST_RESP:   host_ack    = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else if (state == ST_IDLE && req) begin
            addr_q  <= idx;
            wdata_q <= {stage_q[HDATA_W-1 -: HI_W], host_wdata};
            rdata_q <= (kind == ACC_STG_RD) ? stage_q : '0;
        end else if (state == ST_FETCH) begin
            rdata_q <= dev_rdata[HDATA_W-1:0];
        end
    end

    assign stage_hi_data = dev_rdata[REG_W-1:HDATA_W];
    assign host_rdata    = rdata_q;
    assign dev_addr      = addr_q;
    assign dev_wdata     = wdata_q;

endmodule

// File: rtl/split_reg_bridge.sv
module split_reg_bridge
    import split_bridge_pkg::*;
#(
    parameter int HADDR_W = 20,
    parameter int HDATA_W = 16,
    parameter int REG_W = 24,
    parameter int IDX_W = 10,
    parameter int IDX_SHIFT = 4,
    parameter int RST_BIT = 6,
    parameter logic [HADDR_W-1:0] RD_BASE = 20'h80000,
    parameter logic [HADDR_W-1:0] WR_BASE = 20'hA0000,
    parameter logic [HDATA_W-1:0] STAGE_RESET = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_req,
    input  logic               host_we,
    input  logic [HADDR_W-1:0] host_addr,
    input  logic [HDATA_W-1:0] host_wdata,
    output logic               host_ack,
    output logic [HDATA_W-1:0] host_rdata,
    output logic [IDX_W-1:0]   dev_addr,
    output logic               dev_we,
    output logic [REG_W-1:0]   dev_wdata,
    output logic               dev_re,
    input  logic [REG_W-1:0]   dev_rdata,
    output logic               dev_rst_n
);
    localparam int HI_W = REG_W - HDATA_W;

    acc_kind_e          kind;
    logic [IDX_W-1:0]   idx;
    logic [HDATA_W-1:0] stage_q;
    logic               stage_wr;
    logic               stage_hi_ld;
    logic [HI_W-1:0]    stage_hi_data;

    sbr_decode #(
        .HADDR_W  (HADDR_W),
        .IDX_W    (IDX_W),
        .IDX_SHIFT(IDX_SHIFT),
        .RD_BASE  (RD_BASE),
        .WR_BASE  (WR_BASE)
    ) i_decode (
        .addr(host_addr),
        .we  (host_we),
        .kind(kind),
        .idx (idx)
    );

    sbr_stage #(
        .HDATA_W  (HDATA_W),
        .HI_W     (HI_W),
        .RST_BIT  (RST_BIT),
        .RESET_VAL(STAGE_RESET)
    ) i_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (stage_wr),
        .wr_data  (host_wdata),
        .hi_ld    (stage_hi_ld),
        .hi_data  (stage_hi_data),
        .q        (stage_q),
        .dev_rst_n(dev_rst_n)
    );

    sbr_fsm #(
        .HDATA_W(HDATA_W),
        .REG_W  (REG_W),
        .IDX_W  (IDX_W)
    ) i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req          (host_req),
        .kind         (kind),
        .idx          (idx),
        .host_wdata   (host_wdata),
        .stage_q      (stage_q),
        .dev_rdata    (dev_rdata),
        .host_ack     (host_ack),
        .host_rdata   (host_rdata),
        .dev_addr     (dev_addr),
        .dev_re       (dev_re),
        .dev_we       (dev_we),
        .dev_wdata    (dev_wdata),
        .stage_wr     (stage_wr),
        .stage_hi_ld  (stage_hi_ld),
        .stage_hi_data(stage_hi_data)
    );

endmodule

// File: rtl/split_reg_bridge_chk.sv
module split_reg_bridge_chk #(
    parameter int HADDR_W = 20,
    parameter int HDATA_W = 16,
    parameter int IDX_W = 10,
    parameter int IDX_SHIFT = 4,
    parameter int RST_BIT = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               host_req,
    input logic               host_we,
    input logic [HADDR_W-1:0] host_addr,
    input logic [HDATA_W-1:0] host_wdata,
    input logic               host_ack,
    input logic [IDX_W-1:0]   dev_addr,
    input logic               dev_we,
    input logic [HDATA_W-1:0] dev_wdata_lo,
    input logic               dev_re,
    input logic               dev_rst_n
);
    logic busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
        end else if (host_ack) begin
            busy <= 1'b0;
        end else if (host_req) begin
            busy <= 1'b1;
        end
    end

    // R9: input assumption, one request at a time
    a_r9_req_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        host_req |-> !busy);

    a_r9_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);

    a_r9_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |-> busy);

    a_r7_we_single: assert property (@(posedge clk) disable iff (!rst_n)
        dev_we |=> !dev_we);

    a_r7_we_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        dev_we |-> $past(host_req && host_we));

    a_r6_commit_low: assert property (@(posedge clk) disable iff (!rst_n)
        dev_we |-> dev_wdata_lo == $past(host_wdata));

    a_r6_commit_addr: assert property (@(posedge clk) disable iff (!rst_n)
        dev_we |-> dev_addr == $past(host_addr[IDX_SHIFT +: IDX_W]));

    a_r10_re_from_read: assert property (@(posedge clk) disable iff (!rst_n)
        dev_re |-> $past(host_req && !host_we));

    a_r10_re_we_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(dev_re && dev_we));

    a_r3_rst_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && host_we && host_addr == '0) |=> dev_rst_n == $past(host_wdata[RST_BIT]));

    a_r8_misaligned_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && host_addr[IDX_SHIFT-1:0] != '0) |=> (!dev_we && !dev_re));

endmodule

bind split_reg_bridge split_reg_bridge_chk #(
    .HADDR_W  (HADDR_W),
    .HDATA_W  (HDATA_W),
    .IDX_W    (IDX_W),
    .IDX_SHIFT(IDX_SHIFT),
    .RST_BIT  (RST_BIT)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_req    (host_req),
    .host_we     (host_we),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .host_ack    (host_ack),
    .dev_addr    (dev_addr),
    .dev_we      (dev_we),
    .dev_wdata_lo(dev_wdata[HDATA_W-1:0]),
    .dev_re      (dev_re),
    .dev_rst_n   (dev_rst_n)
);

// File: tb/test_split_reg_bridge.sv
`timescale 1ns/1ps
module test_split_reg_bridge;

    localparam logic [19:0] RD_BASE = 20'h80000;
    localparam logic [19:0] WR_BASE = 20'hA0000;
    localparam int NREG = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [19:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic        host_ack;
    logic [15:0] host_rdata;
    logic [9:0]  dev_addr;
    logic        dev_we;
    logic [23:0] dev_wdata;
    logic        dev_re;
    logic [23:0] dev_rdata;
    logic        dev_rst_n;

    int checks = 0;
    int fails = 0;

    always #2 clk = ~clk;

    split_reg_bridge i_split_reg_bridge (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_ack(host_ack), .host_rdata(host_rdata),
        .dev_addr(dev_addr), .dev_we(dev_we), .dev_wdata(dev_wdata),
        .dev_re(dev_re), .dev_rdata(dev_rdata), .dev_rst_n(dev_rst_n)
    );

    function automatic logic [23:0] seed_val(int i);
        logic [31:0] v;
        v = i * 32'h0000A3C5 + 32'h00005A17;
        return v[23:0];
    endfunction

    function automatic logic [19:0] win_addr(logic [19:0] base, logic [9:0] n);
        return base | ({10'b0, n} << 4);
    endfunction

    // device register file model
    logic [23:0] dev_mem [0:NREG-1];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) dev_mem[i] <= seed_val(i);
        end else if (dev_we) begin
            dev_mem[dev_addr] <= dev_wdata;
        end
    end
    assign dev_rdata = dev_mem[dev_addr];

    int we_count = 0;
    int re_count = 0;
    logic [9:0] last_re_addr = '0;
    always @(posedge clk) begin
        if (rst_n && dev_we) we_count <= we_count + 1;
        if (rst_n && dev_re) begin
            re_count <= re_count + 1;
            last_re_addr <= dev_addr;
        end
    end

    logic [23:0] exp_mem [0:NREG-1];
    logic [15:0] exp_stage;

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_acc(input logic we, input logic [19:0] addr, input logic [15:0] wd,
                          output logic [15:0] rd, output int lat);
        @(negedge clk);
        host_req = 1'b1;
        host_we = we;
        host_addr = addr;
        host_wdata = wd;
        @(negedge clk);
        host_req = 1'b0;
        lat = 1;
        while (!host_ack && lat < 8) begin
            @(negedge clk);
            lat++;
        end
        rd = host_rdata;
    endtask

    task automatic stg_wr(logic [15:0] d);
        logic [15:0] rd;
        int lat;
        do_acc(1'b1, 20'h0, d, rd, lat);
        exp_stage = d;
        chk("R9 staging write latency", lat, 1);
        chk("R3 dev_rst_n follows bit 6", {31'b0, dev_rst_n}, {31'b0, d[6]});
    endtask

    task automatic stg_rd_chk(string req);
        logic [15:0] rd;
        int lat;
        do_acc(1'b0, 20'h0, 16'h0, rd, lat);
        chk(req, {16'b0, rd}, {16'b0, exp_stage});
        chk("R9 staging read latency", lat, 1);
    endtask

    task automatic win_rd_chk(logic [9:0] n);
        logic [15:0] rd;
        int lat;
        int rc;
        rc = re_count;
        do_acc(1'b0, win_addr(RD_BASE, n), 16'h0, rd, lat);
        chk("R4 window read low half", {16'b0, rd}, {16'b0, exp_mem[n][15:0]});
        chk("R9 window read latency", lat, 2);
        chk("R10 one dev_re per read", re_count, rc + 1);
        chk("R10 dev_addr on read", {22'b0, last_re_addr}, {22'b0, n});
        exp_stage[15:8] = exp_mem[n][23:16];
    endtask

    task automatic win_wr(logic [9:0] n, logic [15:0] d);
        logic [15:0] rd;
        int lat;
        int wc;
        wc = we_count;
        do_acc(1'b1, win_addr(WR_BASE, n), d, rd, lat);
        exp_mem[n] = {exp_stage[15:8], d};
        chk("R7 one dev_we per commit", we_count, wc + 1);
        chk("R6 committed word", {8'b0, dev_mem[n]}, {8'b0, exp_mem[n]});
        chk("R9 window write latency", lat, 2);
    endtask

    task automatic ign_acc(logic we, logic [19:0] addr, logic [15:0] d);
        logic [15:0] rd;
        int lat;
        int wc;
        int rc;
        wc = we_count;
        rc = re_count;
        do_acc(we, addr, d, rd, lat);
        chk("R8 ignored read data", {16'b0, rd}, 32'h0);
        chk("R8 no dev_we", we_count, wc);
        chk("R8 no dev_re", re_count, rc);
        chk("R9 ignored latency", lat, 1);
    endtask

    initial begin
        #800000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        int bad;
        void'($urandom(32'd2024));
        for (int i = 0; i < NREG; i++) exp_mem[i] = seed_val(i);
        exp_stage = 16'h0000;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 host_ack low", {31'b0, host_ack}, 0);
        chk("R1 dev_we low", {31'b0, dev_we}, 0);
        chk("R1 dev_re low", {31'b0, dev_re}, 0);
        chk("R1 dev_rst_n low", {31'b0, dev_rst_n}, 0);
        stg_rd_chk("R1 staging reset value");

        // R2/R3 staging
        stg_wr(16'h1234);
        stg_rd_chk("R2 staging readback");
        stg_wr(16'hA5C3);
        stg_rd_chk("R2 staging readback 2");
        stg_wr(16'h0040);
        chk("R3 reset released", {31'b0, dev_rst_n}, 1);
        stg_wr(16'hFFBF);
        chk("R3 reset asserted", {31'b0, dev_rst_n}, 0);
        @(negedge clk);
        chk("R9 ack single cycle", {31'b0, host_ack}, 0);

        // R4/R5 window reads at both index ends
        stg_wr(16'h00C7);
        win_rd_chk(10'd0);
        stg_rd_chk("R5 high byte loaded, low byte kept");
        win_rd_chk(10'd1023);
        stg_rd_chk("R5 high byte from last register");

        // R6/R7 two-step writes
        stg_wr(16'h9E40);
        win_wr(10'd0, 16'hBEEF);
        win_rd_chk(10'd0);
        stg_wr(16'h7D41);
        win_wr(10'd1023, 16'h0001);
        win_rd_chk(10'd1023);
        stg_rd_chk("R5 high byte after commit");

        // R8 ignored accesses
        ign_acc(1'b1, win_addr(WR_BASE, 10'd5) | 20'h8, 16'h5555);
        ign_acc(1'b1, win_addr(RD_BASE, 10'd5), 16'h6666);
        ign_acc(1'b0, win_addr(WR_BASE, 10'd5), 16'h0);
        ign_acc(1'b0, 20'h00002, 16'h0);
        ign_acc(1'b1, 20'h40000, 16'h7777);
        stg_rd_chk("R8 staging untouched");

        // random mix
        for (int k = 0; k < 400; k++) begin
            logic [31:0] r;
            logic [9:0] n;
            r = $urandom;
            n = r[17:8];
            case (r[2:0])
                3'd0: stg_wr({r[31:24], r[23:18], 1'b1, r[3]});
                3'd1: stg_rd_chk("R2 random staging read");
                3'd2: win_rd_chk(n);
                3'd3, 3'd4: begin
                    stg_wr({r[31:24], 8'h40});
                    win_wr(n, r[31:16] ^ 16'h3C3C);
                end
                default: begin
                    case (r[4:3])
                        2'd0: ign_acc(1'b1, win_addr(RD_BASE, n), r[31:16]);
                        2'd1: ign_acc(1'b0, win_addr(WR_BASE, n), 16'h0);
                        2'd2: ign_acc(r[5], win_addr(WR_BASE, n) | {16'b0, 4'd1 + 4'(r[22:20])}, r[31:16]);
                        default: ign_acc(r[5], 20'hC0000 | {6'b0, n, 4'b0}, r[31:16]);
                    endcase
                end
            endcase
        end
        stg_rd_chk("R5 staging after random mix");

        bad = 0;
        for (int i = 0; i < NREG; i++) if (dev_mem[i] !== exp_mem[i]) bad++;
        chk("R8 register file matches model", bad, 0);

        report();
        $finish;
    end

endmodule